// File: doc/BRIEF.md
# Audio Frame Serializer

This block is the controller-side transmitter for a serial audio link. A 12.288 MHz bit clock drives it, giving a 256-bit frame every 20.8 µs (48 kHz). The frame starts with a 16-bit header, followed by twelve 20-bit payload slots. The block puts the frame out one bit per rising edge, most significant bit first, so that the receiving codec can sample each bit on the falling edge that follows. A frame marker, `sync`, goes high for the 16 header bit times at the start of each frame.

Frame content comes in as one parallel bundle over a valid/ready handshake:

- a frame-good flag;
- twelve slot tags;
- a 2-bit codec address;
- twelve right-justified samples, each with its own width.

The block raises `in_ready` for exactly one cycle per frame, the cycle just before the frame starts. A bundle is taken only on that edge.

Back-pressure works as follows:

- A producer may raise `in_valid` early. It must then hold the bundle steady until it sees `in_ready`.
- Inputs presented at any other time have no effect on the output.
- If no bundle is offered at the boundary, the next frame goes out as all zeros.

Each taken sample is moved up to the top of its slot, and the bits below it are filled with zeros. A slot whose tag is clear is sent as zeros in full.

Top module: `afs_tx`

## Requirements
- R1: While `rst_n` is low, `sync` and `sdata` are 0 and `in_ready` is 1. On the first rising edge after release, `sync` goes high.
- R2: The frame period is 256 clocks. `sync` is high for 16 consecutive clocks from each rise and low for the following 240.
- R3: `in_ready` is high exactly in the cycle before each rise of `sync`. A bundle is taken only on an edge where both `in_valid` and `in_ready` are high. Input values at all other edges have no effect on `sdata`.
- R4: A taken frame goes out MSB first, one bit per clock, as follows:
  - Frame bit 255 (the header MSB) is driven on the edge after the one on which `sync` rose.
  - Frame bit 0 is driven on the edge on which `sync` next rises.
- R5: The header bits are laid out as follows:
  - Header bit 15 carries the frame-good flag.
  - Header bit 14-s carries the tag for slot s+1 (`in_tag[s]`).
  - Header bit 2 is always 0.
  - Header bits 1..0 carry `in_codec_id`.
- R6: A slot whose tag is 0 is sent as 20 zero bits, whatever its data or width.
- R7: The width of slot s is `w` = `in_width[5s+4:5s]`, with values above 20 treated as 20. The sample's low `w` bits (`in_data[20s +: w]`) occupy slot bits 19..20-w, and the remaining slot bits are 0. A width of 0 gives an all-zero slot.
- R8: When no bundle is taken at a boundary, the whole next frame is zeros. A bundle offered early with `in_valid` held high is taken at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all outputs change on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Frame bundle offered |
| in_ready | output | 1 | Bundle taken on this edge (one cycle per frame) |
| in_frame_ok | input | 1 | Frame-good flag for header bit 15 |
| in_tag | input | 12 | Slot tags, bit s for slot s+1 |
| in_codec_id | input | 2 | Codec address for header bits 1..0 |
| in_data | input | 240 | Right-justified samples, slot s at bits 20s+19..20s |
| in_width | input | 60 | Sample widths, slot s at bits 5s+4..5s |
| sync | output | 1 | Frame marker, high for the header bit times |
| sdata | output | 1 | Serial frame data |

## Verification
The bench builds the block with its default parameters: twelve 20-bit slots behind a 16-bit header, which is the full 256-bit frame. The 5-bit width field reaches values above 20, so the clamp path is exercised along with widths 0, 1 and full. Frames with mixed tags, a clear frame-good flag, idle boundaries, and bundles offered early while junk data changes elsewhere in the frame exercise every masking and handshake path.

// File: rtl/afs_pkg.sv
package afs_pkg;
  localparam int DEF_SLOT_N = 12;
  localparam int DEF_SLOT_W = 20;
  localparam int DEF_HDR_W  = 16;
  localparam int DEF_ID_W   = 2;

  // bits needed to express a width 0..slot_w
  function automatic int width_bits(input int slot_w);
    return $clog2(slot_w + 1);
  endfunction

  // header bit that carries the tag of slot index s (0-based)
  function automatic int tag_pos(input int hdr_w, input int s);
    return hdr_w - 2 - s;
  endfunction
endpackage

// File: rtl/afs_slot_pack.sv
module afs_slot_pack #(
  parameter int SLOT_W = afs_pkg::DEF_SLOT_W,
  parameter int WID_W  = afs_pkg::width_bits(SLOT_W)
) (
  input  logic              tag,
  input  logic [SLOT_W-1:0] raw,
  input  logic [WID_W-1:0]  width,
  output logic [SLOT_W-1:0] word
);
  localparam logic [WID_W-1:0] FULL = WID_W'(SLOT_W);

  logic [WID_W-1:0]  w_eff;
  logic [WID_W-1:0]  lift;
  logic [SLOT_W-1:0] keep;

  always_comb begin
    w_eff = (width > FULL) ? FULL : width;
    lift  = FULL - w_eff;
    for (int i = 0; i < SLOT_W; i++) begin
      keep[i] = (WID_W'(i) < w_eff);
    end
    if (tag) begin
      word = (raw & keep) << lift;
    end else begin
      word = '0;
    end
  end
endmodule

// File: rtl/afs_frame_build.sv
module afs_frame_build #(
  parameter int SLOT_N = afs_pkg::DEF_SLOT_N,
  parameter int SLOT_W = afs_pkg::DEF_SLOT_W,
  parameter int HDR_W  = afs_pkg::DEF_HDR_W,
  parameter int ID_W   = afs_pkg::DEF_ID_W,
  parameter int WID_W  = afs_pkg::width_bits(SLOT_W),
  parameter int FRAME_LEN = HDR_W + SLOT_N * SLOT_W
) (
  input  logic                     take,
  input  logic                     frame_ok,
  input  logic [SLOT_N-1:0]        tag,
  input  logic [ID_W-1:0]          codec_id,
  input  logic [SLOT_N*SLOT_W-1:0] data,
  input  logic [SLOT_N*WID_W-1:0]  width,
  output logic [FRAME_LEN-1:0]     frame
);
  localparam int BODY_W = SLOT_N * SLOT_W;

  logic [HDR_W-1:0]  hdr;
  logic [BODY_W-1:0] body;

  for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
    logic [SLOT_W-1:0] word;
    afs_slot_pack #(.SLOT_W(SLOT_W), .WID_W(WID_W)) u_pack (
      .tag   (tag[s]),
      .raw   (data[s*SLOT_W +: SLOT_W]),
      .width (width[s*WID_W +: WID_W]),
      .word  (word)
    );
    // slot 1 sits right below the header, later slots follow
    assign body[BODY_W-1-s*SLOT_W -: SLOT_W] = word;
  end

  always_comb begin
    hdr = '0;
    hdr[HDR_W-1] = frame_ok;
    for (int s = 0; s < SLOT_N; s++) begin
      hdr[afs_pkg::tag_pos(HDR_W, s)] = tag[s];
    end
    hdr[ID_W-1:0] = codec_id;
  end

  assign frame = take ? {hdr, body} : '0;
endmodule

// File: rtl/afs_frame_timer.sv
module afs_frame_timer #(
  parameter int FRAME_LEN = 256,
  parameter int SYNC_LEN  = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic boundary,
  output logic sync
);
  localparam int POS_W = $clog2(FRAME_LEN);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);
  localparam logic [POS_W-1:0] HIGH = POS_W'(SYNC_LEN);

  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] pos_nx;

  assign boundary = (pos == LAST);
  assign pos_nx   = boundary ? '0 : pos + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos  <= LAST;
      sync <= 1'b0;
    end else begin
      pos  <= pos_nx;
      sync <= (pos_nx < HIGH);
    end
  end
endmodule

// File: rtl/afs_shifter.sv
module afs_shifter #(
  parameter int FRAME_LEN = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [FRAME_LEN-1:0] frame_in,
  output logic                 sdata
);
  logic [FRAME_LEN-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '0;
      sdata <= 1'b0;
    end else begin
      sdata <= sh[FRAME_LEN-1];
      if (load) begin
        sh <= frame_in;
      end else begin
        sh <= {sh[FRAME_LEN-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/afs_tx.sv
module afs_tx #(
  parameter int SLOT_N = afs_pkg::DEF_SLOT_N,
  parameter int SLOT_W = afs_pkg::DEF_SLOT_W,
  parameter int HDR_W  = afs_pkg::DEF_HDR_W,
  parameter int ID_W   = afs_pkg::DEF_ID_W,
  parameter int WID_W  = afs_pkg::width_bits(SLOT_W)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic                     in_frame_ok,
  input  logic [SLOT_N-1:0]        in_tag,
  input  logic [ID_W-1:0]          in_codec_id,
  input  logic [SLOT_N*SLOT_W-1:0] in_data,
  input  logic [SLOT_N*WID_W-1:0]  in_width,
  output logic                     sync,
  output logic                     sdata
);
  localparam int FRAME_LEN = HDR_W + SLOT_N * SLOT_W;

  logic                 boundary;
  logic [FRAME_LEN-1:0] frame;

  afs_frame_timer #(.FRAME_LEN(FRAME_LEN), .SYNC_LEN(HDR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .boundary (boundary),
    .sync     (sync)
  );

  afs_frame_build #(
    .SLOT_N(SLOT_N), .SLOT_W(SLOT_W), .HDR_W(HDR_W), .ID_W(ID_W),
    .WID_W(WID_W), .FRAME_LEN(FRAME_LEN)
  ) u_build (
    .take     (in_valid),
    .frame_ok (in_frame_ok),
    .tag      (in_tag),
    .codec_id (in_codec_id),
    .data     (in_data),
    .width    (in_width),
    .frame    (frame)
  );

  afs_shifter #(.FRAME_LEN(FRAME_LEN)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (boundary),
    .frame_in (frame),
    .sdata    (sdata)
  );

  assign in_ready = boundary;
endmodule

// File: rtl/afs_tx_chk.sv
module afs_tx_chk #(
  parameter int FRAME_LEN = 256,
  parameter int SYNC_LEN  = 16,
  parameter int HDR_W     = 16
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic sync,
  input logic sdata
);
  localparam int CW = $clog2(FRAME_LEN) + 2;
  localparam logic [CW-1:0] C_MAX  = '1;
  localparam logic [CW-1:0] C_LEN  = CW'(FRAME_LEN);
  localparam logic [CW-1:0] C_HIGH = CW'(SYNC_LEN);
  localparam logic [CW-1:0] C_RSV  = CW'(HDR_W - 2);

  logic          sync_d;
  logic          seen;
  logic          hs_d;
  logic          idle;
  logic [CW-1:0] c;
  logic          rise_now;

  assign rise_now = sync && !sync_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_d <= 1'b0;
      seen   <= 1'b0;
      hs_d   <= 1'b0;
      idle   <= 1'b0;
      c      <= '0;
    end else begin
      sync_d <= sync;
      hs_d   <= in_valid && in_ready;
      if (rise_now) begin
        seen <= 1'b1;
        idle <= !hs_d;
        c    <= CW'(1);
      end else if (c != C_MAX) begin
        c <= c + 1'b1;
      end
    end
  end

  assert_sync_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !rise_now && c < C_HIGH) |-> sync);
  assert_sync_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !rise_now && c >= C_HIGH) |-> !sync);
  assert_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_now && seen) |-> (c == C_LEN));
  assert_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> $rose(sync));
  assert_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync) |-> $past(in_ready));
  assert_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !rise_now && c == C_RSV) |-> !sdata);
  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !rise_now) |-> !sdata);
endmodule

bind afs_tx afs_tx_chk #(
  .FRAME_LEN(FRAME_LEN), .SYNC_LEN(HDR_W), .HDR_W(HDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .sync     (sync),
  .sdata    (sdata)
);

// File: tb/afs_tx_tb.sv
module afs_tx_tb;
  localparam int NS = 12;
  localparam int SW = 20;
  localparam int WW = 5;
  localparam int FL = 256;
  localparam int NFRAMES = 7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic            in_frame_ok = 1'b0;
  logic [NS-1:0]   in_tag = '0;
  logic [1:0]      in_codec_id = '0;
  logic [NS*SW-1:0] in_data = '0;
  logic [NS*WW-1:0] in_width = '0;
  logic            sync;
  logic            sdata;

  int vectors = 0;
  int fails = 0;

  logic [FL-1:0] mframe = '0;
  logic exp_sync = 1'b0;
  logic exp_sdata = 1'b0;
  logic exp_ready = 1'b1;

  always #5 clk = ~clk;

  afs_tx u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_frame_ok(in_frame_ok), .in_tag(in_tag), .in_codec_id(in_codec_id),
    .in_data(in_data), .in_width(in_width), .sync(sync), .sdata(sdata)
  );

  function automatic logic [FL-1:0] ref_frame(
    input logic ok, input logic [NS-1:0] tg, input logic [1:0] id,
    input logic [NS*SW-1:0] d, input logic [NS*WW-1:0] w);
    logic [FL-1:0] f;
    f = '0;
    f[255] = ok;
    for (int s = 0; s < NS; s++) f[254 - s] = tg[s];
    f[241:240] = id;
    for (int s = 0; s < NS; s++) begin
      if (tg[s]) begin
        int wi;
        wi = int'(w[s*WW +: WW]);
        if (wi > SW) wi = SW;
        for (int b = 0; b < wi; b++) f[240 - SW*s - wi + b] = d[s*SW + b];
      end
    end
    return f;
  endfunction

  function automatic string req_of(input int fi);
    case (fi)
      0: return "R4";
      1: return "R6";
      2: return "R7";
      3: return "R8";
      4: return "R5";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  // drive the bundle planned for frame fi
  task automatic drive_plan(input int fi);
    logic [NS*SW-1:0] d;
    logic [NS*WW-1:0] w;
    int wl [NS] = '{0, 1, 8, 16, 19, 20, 21, 31, 8, 12, 5, 3};
    d = '0;
    w = '0;
    in_valid = 1'b1;
    case (fi)
      0: begin // R4 full frame, all slots 20 bits
        in_frame_ok = 1'b1; in_tag = '1; in_codec_id = 2'b01;
        for (int s = 0; s < NS; s++) begin
          d[s*SW +: SW] = 20'h0A5A5 ^ (20'h11111 * (s + 1));
          w[s*WW +: WW] = 5'd20;
        end
      end
      1: begin // R6 mixed tags
        in_frame_ok = 1'b1; in_tag = 12'b1010_0110_0101; in_codec_id = 2'b10;
        for (int s = 0; s < NS; s++) begin
          d[s*SW +: SW] = '1;
          w[s*WW +: WW] = 5'd20;
        end
      end
      2: begin // R7 width clamp and justification
        in_frame_ok = 1'b1; in_tag = '1; in_codec_id = 2'b11;
        for (int s = 0; s < NS; s++) begin
          d[s*SW +: SW] = 20'hFFFFF ^ (20'h01234 << s);
          w[s*WW +: WW] = WW'(wl[s]);
        end
      end
      4: begin // R5 frame-good clear, tags still sent
        in_frame_ok = 1'b0; in_tag = 12'h0F3; in_codec_id = 2'b11;
        for (int s = 0; s < NS; s++) begin
          d[s*SW +: SW] = 20'h5A5A5;
          w[s*WW +: WW] = 5'd20;
        end
      end
      5: begin // R7 8-bit samples with junk above
        in_frame_ok = 1'b1; in_tag = '1; in_codec_id = 2'b00;
        for (int s = 0; s < NS; s++) begin
          d[s*SW +: SW] = 20'hFFFA5 - 20'(s);
          w[s*WW +: WW] = 5'd8;
        end
      end
      default: in_valid = 1'b0; // R8 idle boundary
    endcase
    in_data = d;
    in_width = w;
  endtask

  task automatic drive_junk();
    in_valid = 1'b0;
    in_frame_ok = 1'($urandom);
    in_tag = NS'($urandom);
    in_codec_id = 2'($urandom);
    for (int s = 0; s < NS; s++) begin
      in_data[s*SW +: SW] = SW'($urandom);
      in_width[s*WW +: WW] = WW'($urandom);
    end
  endtask

  task automatic compare(input string rq);
    vectors++;
    if (sync !== exp_sync) begin
      fails++;
      $display("FAIL R2 (%s) sync=%b expected %b at %0t", rq, sync, exp_sync, $time);
    end
    if (sdata !== exp_sdata) begin
      fails++;
      $display("FAIL %s sdata=%b expected %b at %0t", rq, sdata, exp_sdata, $time);
    end
    if (in_ready !== exp_ready) begin
      fails++;
      $display("FAIL R3 in_ready=%b expected %b at %0t", in_ready, exp_ready, $time);
    end
  endtask

  initial begin : watchdog
    #1500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : stim
    // R1: reset state
    repeat (4) begin
      @(negedge clk);
      compare("R1");
    end
    rst_n = 1'b1;
    for (int e = 0; e <= NFRAMES * FL + 1; e++) begin
      int ph;
      int fi;
      logic take;
      ph = e % FL;
      fi = e / FL;
      if (ph == 0) drive_plan(fi);
      else if (ph >= FL - 40) drive_plan(fi + 1); // R8 early offer held
      else drive_junk();                           // R3 junk ignored
      take = exp_ready && in_valid;
      exp_sync = (ph < 16);
      if (ph == 0) begin
        exp_sdata = mframe[0];
        mframe = take ? ref_frame(in_frame_ok, in_tag, in_codec_id, in_data, in_width) : '0;
      end else begin
        exp_sdata = mframe[FL - ph];
      end
      exp_ready = (ph == FL - 1);
      @(negedge clk);
      compare(req_of((e == 0) ? 0 : (e - 1) / FL));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule